// File: doc/BRIEF.md
# SHA-1 Four-Round Step Unit

This block moves a SHA-1 working state forward by four rounds in one operation. It takes a 128-bit word with the four chaining variables A, B, C and D, and a second 128-bit word with four message terms that are already summed. The leading term of that second word already contains the fifth variable E. A 2-bit selector picks one round function and one round constant, and that pair is used for all four rounds. The result is the new A..D state in the same lane layout as the input, so a controller can feed the output straight back in for the next group of four rounds.

The datapath is four combinational round slices in a chain. A parameter adds an optional output register with a valid/ready handshake. With the register present, a result appears one cycle after its input is accepted and stays stable until the consumer takes it. Message schedule expansion, padding, the final addition into the hash value and any sequencing across the 80 rounds are left to the surrounding logic.

Top module: `sha4_step`

## Requirements
- R1: State lanes: `in_state` and `out_state` hold A in bits 127:96, B in 95:64, C in 63:32 and D in 31:0.
- R2: Message lanes: `in_msg` bits 127:96 hold W0+E (E is not added again in round one), bits 95:64 hold W1, 63:32 hold W2 and 31:0 hold W3.
- R3: `in_sel` value 0 selects choose(B,C,D)=(B&C)|(~B&D) with constant 32'h5A827999. Value 1 selects B^C^D with 32'h6ED9EBA1. Value 2 selects majority(B,C,D) with 32'h8F1BBCDC. Value 3 selects B^C^D with 32'hCA62C1D6. The same pair applies to all four rounds.
- R4: Rounds two to four compute new A = f(B,C,D) + (A rotl 5) + Wi + E + K, where E is the D of the previous round.
- R5: Each round passes the state along: new B = A, new C = B rotl 30, new D = C, new E = D.
- R6: All sums are taken modulo 2^32 and any carry out of bit 31 is dropped.
- R7: With the output register enabled, `out_valid` rises in the cycle after a transfer where `in_valid` and `in_ready` are both high.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_state` stay unchanged.
- R9: `in_ready` is high whenever the output register is empty or being drained in the same cycle, so a new input can be accepted while the current result leaves. The register empties when it is drained and no new input arrives.
- R10: After synchronous active-high reset `rst`, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input operands are present |
| in_ready | output | 1 | Unit can accept operands this cycle |
| in_state | input | 128 | Packed A, B, C, D |
| in_msg | input | 128 | Packed W0+E, W1, W2, W3 |
| in_sel | input | 2 | Round function and constant select |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_state | output | 128 | Updated A, B, C, D after four rounds |

## Verification
The first four rounds of the standard three-byte "abc" message are applied as a known answer. This fixes the lane order, the folding of E into the first term and the choose function. Table vectors run each selector value over unrelated states, so a wrong function or constant, or swapped parity and majority, gives a different result from the bench's own loop model. An all-ones operand set forces carries through every adder. Handshake sequences with the consumer stalled, released and drained at the same moment as a new input separate the hold, latency and pass-through behaviour of the output register.

// File: rtl/sha4_pkg.sv
package sha4_pkg;

    localparam int WORD_W  = 32;
    localparam int LANES   = 4;
    localparam int ROUNDS  = LANES;
    localparam int BLOCK_W = WORD_W * LANES;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        FN_CHOOSE   = 2'd0,
        FN_PARITY_A = 2'd1,
        FN_MAJORITY = 2'd2,
        FN_PARITY_B = 2'd3
    } fsel_e;

    // Four-variable view matching the packed 128-bit lane order
    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
    } abcd_t;

    // Working state carried between round slices
    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
    } abcde_t;

    function automatic word_t rotl(input word_t x, input int unsigned n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    function automatic word_t round_const(input fsel_e sel);
        case (sel)
            FN_CHOOSE:   return 32'h5A827999;
            FN_PARITY_A: return 32'h6ED9EBA1;
            FN_MAJORITY: return 32'h8F1BBCDC;
            default:     return 32'hCA62C1D6;
        endcase
    endfunction

    function automatic word_t round_fn(input fsel_e sel, input word_t b,
                                       input word_t c, input word_t d);
        case (sel)
            FN_CHOOSE:   return (b & c) | (~b & d);
            FN_MAJORITY: return (b & c) | (b & d) | (c & d);
            default:     return b ^ c ^ d;
        endcase
    endfunction

    // Lane 0 is the most significant word
    function automatic word_t lane(input logic [BLOCK_W-1:0] blk, input int idx);
        return blk[BLOCK_W-1-WORD_W*idx -: WORD_W];
    endfunction

endpackage

// File: rtl/sha4_round.sv
module sha4_round
    import sha4_pkg::*;
(
    input  abcde_t cur,
    input  word_t  w_term,
    input  fsel_e  sel,
    output abcde_t nxt
);
    word_t sum;

    always_comb begin
        sum = rotl(cur.a, 5) + round_fn(sel, cur.b, cur.c, cur.d)
            + cur.e + w_term + round_const(sel);
        nxt.a = sum;
        nxt.b = cur.a;
        nxt.c = rotl(cur.b, 30);
        nxt.d = cur.c;
        nxt.e = cur.d;
    end
endmodule

// File: rtl/sha4_core.sv
module sha4_core
    import sha4_pkg::*;
(
    input  abcd_t                 st_in,
    input  logic [BLOCK_W-1:0]    msg_in,
    input  fsel_e                 sel,
    output abcd_t                 st_out
);
    abcde_t chain [ROUNDS+1];
    word_t  unused_tail_e;

    // E is folded into the first message term, so the first slice sees zero
    assign chain[0] = '{a: st_in.a, b: st_in.b, c: st_in.c, d: st_in.d, e: '0};

    generate
        for (genvar r = 0; r < ROUNDS; r++) begin : g_rnd
            sha4_round u_rnd (
                .cur    (chain[r]),
                .w_term (lane(msg_in, r)),
                .sel    (sel),
                .nxt    (chain[r+1])
            );
        end
    endgenerate

    assign st_out = '{a: chain[ROUNDS].a, b: chain[ROUNDS].b,
                      c: chain[ROUNDS].c, d: chain[ROUNDS].d};
    assign unused_tail_e = chain[ROUNDS].e;
endmodule

// File: rtl/sha4_out_stage.sv
module sha4_out_stage #(
    parameter int W       = 128,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    generate
        if (REG_OUT) begin : g_reg
            logic         v_q;
            logic [W-1:0] d_q;

            assign in_ready  = !v_q || out_ready;
            assign out_valid = v_q;
            assign out_data  = d_q;

            always_ff @(posedge clk) begin
                if (rst)
                    v_q <= 1'b0;
                else if (in_ready)
                    v_q <= in_valid;
            end

            always_ff @(posedge clk) begin
                if (in_valid && in_ready)
                    d_q <= in_data;
            end

            p_accept_r7: assert property (@(posedge clk) disable iff (rst)
                in_valid && in_ready |=> out_valid);

            p_hold_r8: assert property (@(posedge clk) disable iff (rst)
                out_valid && !out_ready |=> out_valid && $stable(out_data));

            p_drain_r9: assert property (@(posedge clk) disable iff (rst)
                out_valid && out_ready && !in_valid |=> !out_valid);

            p_reset_r10: assert property (@(posedge clk)
                rst |=> !out_valid && in_ready);
        end else begin : g_wire
            assign in_ready  = out_ready;
            assign out_valid = in_valid;
            assign out_data  = in_data;
        end
    endgenerate
endmodule

// File: rtl/sha4_step.sv
module sha4_step
    import sha4_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [127:0]       in_state,
    input  logic [127:0]       in_msg,
    input  logic [1:0]         in_sel,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [127:0]       out_state
);
    abcd_t core_out;

    sha4_core u_core (
        .st_in  (abcd_t'(in_state)),
        .msg_in (in_msg),
        .sel    (fsel_e'(in_sel)),
        .st_out (core_out)
    );

    sha4_out_stage #(
        .W       (BLOCK_W),
        .REG_OUT (REG_OUT)
    ) u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (core_out),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_state)
    );
endmodule

// File: tb/sha4_step_test.sv
module sha4_step_test;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_ready;
    logic [127:0] in_state;
    logic [127:0] in_msg;
    logic [1:0]   in_sel;
    logic         out_valid;
    logic         out_ready;
    logic [127:0] out_state;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sha4_step uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_state(in_state), .in_msg(in_msg), .in_sel(in_sel),
        .out_valid(out_valid), .out_ready(out_ready), .out_state(out_state)
    );

    // {sel, state, msg}
    localparam logic [257:0] VECS [8] = '{
        {2'd0, 128'h0123456789ABCDEF_FEDCBA9876543210, 128'h00000001_00000002_00000003_00000004},
        {2'd1, 128'hDEADBEEF_CAFEBABE_12345678_9ABCDEF0, 128'h0F0F0F0F_F0F0F0F0_33333333_CCCCCCCC},
        {2'd2, 128'h80000000_7FFFFFFF_AAAAAAAA_55555555, 128'h11111111_22222222_44444444_88888888},
        {2'd3, 128'h13579BDF_2468ACE0_FFFF0000_0000FFFF, 128'hA5A5A5A5_5A5A5A5A_C3C3C3C3_3C3C3C3C},
        {2'd0, 128'h00000000_00000000_00000000_00000000, 128'h00000000_00000000_00000000_00000000},
        {2'd1, 128'h67452301_EFCDAB89_98BADCFE_10325476, 128'hC3D2E1F0_00000000_00000000_00000018},
        {2'd2, 128'hFFFFFFFF_00000000_FFFFFFFF_00000000, 128'h00000000_FFFFFFFF_00000000_FFFFFFFF},
        {2'd3, 128'h89ABCDEF_01234567_76543210_FEDCBA98, 128'h9E3779B9_7F4A7C15_F39CC060_5CEDC834}
    };

    // Behavioural four-round model built from the requirement text
    function automatic logic [127:0] model(input logic [1:0] sel,
                                           input logic [127:0] st,
                                           input logic [127:0] m);
        logic [31:0] a, b, c, d, e, f, k, t;
        a = st[127:96]; b = st[95:64]; c = st[63:32]; d = st[31:0]; e = 32'd0;
        for (int r = 0; r < 4; r++) begin
            case (sel)
                2'd0: begin f = d ^ (b & (c ^ d)); k = 32'h5A827999; end
                2'd1: begin f = b ^ c ^ d;         k = 32'h6ED9EBA1; end
                2'd2: begin f = (b & c) | (d & (b | c)); k = 32'h8F1BBCDC; end
                default: begin f = b ^ c ^ d;      k = 32'hCA62C1D6; end
            endcase
            t = {a[26:0], a[31:27]} + f + e + m[127-32*r -: 32] + k;
            e = d;
            d = c;
            c = {b[1:0], b[31:2]};
            b = a;
            a = t;
        end
        return {a, b, c, d};
    endfunction

    task automatic check(input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Accept one operand set with the consumer ready; returns the result
    task automatic push(input logic [1:0] s, input logic [127:0] st,
                        input logic [127:0] m, output logic [127:0] res,
                        output logic vld);
        @(negedge clk);
        in_sel = s; in_state = st; in_msg = m;
        in_valid = 1'b1; out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        res = out_state;
        vld = out_valid;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [127:0] res, exp_a, exp_b;
        logic         vld;
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
        in_state = '0; in_msg = '0; in_sel = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 reset out_valid", {127'd0, out_valid}, 128'd0);
        check("R10 reset in_ready", {127'd0, in_ready}, 128'd1);
        rst = 1'b0;

        // Known answer: rounds 0..3 of "abc", E folded into first term (R1 R2 R3)
        push(2'd0, 128'h67452301_EFCDAB89_98BADCFE_10325476,
             128'h25354570_00000000_00000000_00000000, res, vld);
        check("R1 R2 known answer", res, 128'hCDD8E11B_A1390F08_626414DB_C045BF0C);
        check("R7 valid after accept", {127'd0, vld}, 128'd1);

        // Table walk: every selector, R3 R4 R5
        for (int i = 0; i < 8; i++) begin
            push(VECS[i][257:256], VECS[i][255:128], VECS[i][127:0], res, vld);
            check("R3 R4 R5 table vector", res,
                  model(VECS[i][257:256], VECS[i][255:128], VECS[i][127:0]));
        end

        // Carries through every adder (R6)
        push(2'd2, {128{1'b1}}, {128{1'b1}}, res, vld);
        check("R6 wraparound", res, model(2'd2, {128{1'b1}}, {128{1'b1}}));

        // Stall and release (R7 R8 R9)
        exp_a = model(2'd1, VECS[1][255:128], VECS[2][127:0]);
        exp_b = model(2'd3, VECS[3][255:128], VECS[5][127:0]);
        @(negedge clk);
        check("R9 drained when idle", {127'd0, out_valid}, 128'd0);
        out_ready = 1'b0; in_valid = 1'b1; in_sel = 2'd1;
        in_state = VECS[1][255:128]; in_msg = VECS[2][127:0];
        @(posedge clk);
        @(negedge clk);
        check("R7 result A", out_state, exp_a);
        check("R9 not ready when full", {127'd0, in_ready}, 128'd0);
        in_sel = 2'd3; in_state = VECS[3][255:128]; in_msg = VECS[5][127:0];
        @(posedge clk);
        @(negedge clk);
        check("R8 held data", out_state, exp_a);
        check("R8 held valid", {127'd0, out_valid}, 128'd1);
        out_ready = 1'b1;
        #1;
        check("R9 ready while draining", {127'd0, in_ready}, 128'd1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 pass-through accept", out_state, exp_b);
        check("R9 valid on pass-through", {127'd0, out_valid}, 128'd1);
        @(posedge clk);
        @(negedge clk);
        check("R9 empties on drain", {127'd0, out_valid}, 128'd0);

        // Reset while holding a result (R10)
        out_ready = 1'b0; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R10 reset clears valid", {127'd0, out_valid}, 128'd0);
        rst = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule